// File: doc/BRIEF.md
# Watchdog Timer with Selectable Tick Rate

This block watches for runaway software. A 12-bit counter starts at all ones and counts down by one on each tick from a free-running prescaler. Software proves it is alive by writing to the counter register, which reloads the count to all ones. If no write arrives before the top bit of the counter falls to zero, the block raises an interrupt request and reloads the counter on its own.

The tick comes from one of two taps of the prescaler: the system clock divided by 512 or divided by 32. A flag in a second register picks the tap. While the stop-instruction input is high, the block always uses the faster tap. The counter also reloads when that input rises. A hold input freezes the count. A disable input stops all counting and all interrupt generation. The interrupt request stays high until the interrupt controller acknowledges it.

Top module: `wdt_top`

## Requirements
- R1: The counter is 12 bits wide. Apart from a reload, it changes only by decreasing by exactly one on a selected tick.
- R2: The rate flag is bit 0 of address 0x61. With the flag at 0 the counter takes one tick every 512 clocks. With the flag at 1 it takes one tick every 32 clocks. A read of 0x61 returns the flag in bit 0 and zeros in every other bit. A read of any unmapped address returns zero.
- R3: After reset the counter reads 0xFFF at address 0x60 (bits 11:0, upper bits zero), the flag reads 0, and the interrupt request is low.
- R4: A write to address 0x60 reloads the counter to 0xFFF in the next cycle. The written data value has no effect.
- R5: On the tick that would take the counter from 0x800 to 0x7FF, the interrupt request is set and the counter reloads to 0xFFF in the same cycle. The top bit of the counter never reads 0.
- R6: A rising edge on the stop-instruction input reloads the counter to 0xFFF.
- R7: While the stop-instruction input is high, the tick rate is one every 32 clocks, whatever the flag holds.
- R8: While hold is high, the counter keeps its value, unless it is reloaded.
- R9: While disable is high, the counter does not decrement and no interrupt request is raised.
- R10: The interrupt request stays high until the acknowledge input is high at a clock edge. If an expiry occurs in the same cycle as the acknowledge, the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stp_i | input | 1 | Stop instruction active |
| hold_i | input | 1 | Freeze the count |
| dis_i | input | 1 | Disable counting and interrupts |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge |

## Verification
The counter can be read back, so a wrong tick rate shows up after a single tick period. Over any window of 32 or 512 clocks, a read of address 0x60 changes by a count that differs from the expected one. A wrong reload or a wrong expiry point shows up within one tick of the 0x800 value: either the request is late or early, or the counter reads something other than 0xFFF. A faulty request latch shows up one cycle after an acknowledge, or on the next expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WDT_CNT_W    = 12;
    localparam int WDT_PRE_W    = 9;
    localparam int WDT_FAST_TAP = 4;
    localparam int WDT_SLOW_TAP = 8;
    localparam int WDT_ADDR_W   = 8;
    localparam int WDT_DATA_W   = 16;
    localparam logic [WDT_ADDR_W-1:0] WDT_CNT_ADDR = 8'h60;
    localparam logic [WDT_ADDR_W-1:0] WDT_SEL_ADDR = 8'h61;

    typedef enum logic {
        SEL_SLOW = 1'b0,
        SEL_FAST = 1'b1
    } tick_sel_e;

    typedef struct packed {
        logic cnt_wr;
        logic sel_wr;
        logic stp_rise;
    } wdt_cmd_t;

    function automatic logic tap_done(input logic [WDT_PRE_W-1:0] pre, input int tap);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < WDT_PRE_W; i++) begin
            if (i <= tap && !pre[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int PRE_W    = WDT_PRE_W,
    parameter int FAST_TAP = WDT_FAST_TAP,
    parameter int SLOW_TAP = WDT_SLOW_TAP
) (
    input  logic clk,
    input  logic rst,
    output logic tick_fast,
    output logic tick_slow
);
    localparam int NTAPS = 2;
    localparam int TAPS [NTAPS] = '{FAST_TAP, SLOW_TAP};

    logic [PRE_W-1:0] pre_q;
    logic [NTAPS-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        assign ticks[g] = &pre_q[TAPS[g]:0];
    end

    assign tick_fast = ticks[0];
    assign tick_slow = ticks[1];
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt
    import wdt_pkg::*;
#(
    parameter int CNT_W = WDT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             hold,
    input  logic             dis,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_dec;
    logic             step;

    always_comb begin
        step    = tick && !hold && !dis && !reload;
        cnt_dec = cnt_q - 1'b1;
        expire  = step && !cnt_dec[CNT_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= CNT_TOP;
        else if (reload || expire) cnt_q <= CNT_TOP;
        else if (step)            cnt_q <= cnt_dec;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ack,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)         irq_q <= 1'b0;
        else if (expire) irq_q <= 1'b1;
        else if (ack)    irq_q <= 1'b0;
    end

    assign irq = irq_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W  = WDT_CNT_W,
    parameter int PRE_W  = WDT_PRE_W,
    parameter int ADDR_W = WDT_ADDR_W,
    parameter int DATA_W = WDT_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stp_i,
    input  logic              hold_i,
    input  logic              dis_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    input  logic              irq_ack_i
);
    wdt_cmd_t         cmd;
    tick_sel_e        sel_q;
    logic             stp_q;
    logic             tick_fast;
    logic             tick_slow;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] cnt_q;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:1];

    always_comb begin
        cmd.cnt_wr   = reg_wr && (reg_addr == WDT_CNT_ADDR);
        cmd.sel_wr   = reg_wr && (reg_addr == WDT_SEL_ADDR);
        cmd.stp_rise = stp_i && !stp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_SLOW;
            stp_q <= 1'b0;
        end else begin
            stp_q <= stp_i;
            if (cmd.sel_wr) sel_q <= tick_sel_e'(reg_wdata[0]);
        end
    end

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow)
    );

    assign tick = (stp_i || sel_q == SEL_FAST) ? tick_fast : tick_slow;

    wdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .hold   (hold_i),
        .dis    (dis_i),
        .reload (cmd.cnt_wr || cmd.stp_rise),
        .cnt    (cnt_q),
        .expire (expire)
    );

    wdt_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .ack    (irq_ack_i),
        .irq    (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == WDT_CNT_ADDR)      reg_rdata[CNT_W-1:0] = cnt_q;
        else if (reg_addr == WDT_SEL_ADDR) reg_rdata[0] = sel_q;
    end
endmodule

// File: rtl/wdt_top_checker.sv
module wdt_top_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W  = WDT_CNT_W,
    parameter int ADDR_W = WDT_ADDR_W,
    parameter int DATA_W = WDT_DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt,
    input logic              irq,
    input logic              ack,
    input logic              hold,
    input logic              dis,
    input logic              cnt_wr,
    input logic              stp_rise,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata
);
    localparam logic [CNT_W-1:0] TOP = '1;

    assert_step_by_one_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt) && cnt != TOP) |-> (cnt == $past(cnt) - 1'b1));

    assert_flag_read_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == WDT_SEL_ADDR) |-> (rdata[DATA_W-1:1] == '0));

    assert_write_reload_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == TOP));

    assert_msb_high_R5: assert property (@(posedge clk) disable iff (rst)
        cnt[CNT_W-1]);

    assert_stop_reload_R6: assert property (@(posedge clk) disable iff (rst)
        stp_rise |=> (cnt == TOP));

    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (hold && !cnt_wr && !stp_rise) |=> $stable(cnt));

    assert_no_irq_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        dis |=> !$rose(irq));

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);
endmodule

bind wdt_top wdt_top_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_q),
    .irq      (irq_o),
    .ack      (irq_ack_i),
    .hold     (hold_i),
    .dis      (dis_i),
    .cnt_wr   (cmd.cnt_wr),
    .stp_rise (cmd.stp_rise),
    .addr     (reg_addr),
    .rdata    (reg_rdata)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stp_i = 1'b0;
    logic        hold_i = 1'b0;
    logic        dis_i = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h60;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;
    logic        irq_ack_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_top u_wdt_top (
        .clk       (clk),
        .rst       (rst),
        .stp_i     (stp_i),
        .hold_i    (hold_i),
        .dis_i     (dis_i),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .irq_ack_i (irq_ack_i)
    );

    typedef struct packed {
        logic        flag;
        logic        stp;
        logic        hold;
        logic        dis;
        logic [15:0] cycles;
        logic [11:0] dec;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'd1024, 12'd2},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'd320,  12'd10},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'd320,  12'd10},
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'd320,  12'd0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'd320,  12'd0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'd640,  12'd20}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h60;
        #1;
    endtask

    task automatic read_at(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 8'h60;
        #1;
    endtask

    task automatic wait_for_800(output bit found);
        found = 1'b0;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            #1;
            if (reg_rdata == 16'h0800) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] rd;
        bit found;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R3: reset state
        read_at(8'h60, rd); check("R3 counter", rd, 16'h0FFF);
        read_at(8'h61, rd); check("R3 flag", rd, 16'h0000);
        check("R3 irq", {15'b0, irq_o}, 16'h0000);
        read_at(8'h42, rd); check("R2 unmapped", rd, 16'h0000);

        // R2: flag read returns only bit 0
        reg_write(8'h61, 16'hFFFF);
        read_at(8'h61, rd); check("R2 flag set", rd, 16'h0001);
        reg_write(8'h61, 16'hFFFE);
        read_at(8'h61, rd); check("R2 flag clear", rd, 16'h0000);

        // R1/R2/R7/R8/R9: table of rate cases
        for (int v = 0; v < NV; v++) begin
            reg_write(8'h61, {15'b0, VECS[v].flag});
            stp_i = VECS[v].stp; hold_i = VECS[v].hold; dis_i = VECS[v].dis;
            reg_write(8'h60, 16'h0000);
            repeat (int'(VECS[v].cycles) - 1) @(negedge clk);
            #1;
            read_at(8'h60, rd);
            check($sformatf("R1 R2 R7 R8 R9 vector %0d", v), rd, 16'h0FFF - {4'b0, VECS[v].dec});
            check($sformatf("R9 no irq vector %0d", v), {15'b0, irq_o}, 16'h0000);
            stp_i = 1'b0; hold_i = 1'b0; dis_i = 1'b0;
        end

        // R4: write data ignored, reload to FFF
        reg_write(8'h61, 16'h0001);
        repeat (320) @(negedge clk);
        reg_write(8'h60, 16'h0123);
        read_at(8'h60, rd); check("R4 write reload", rd, 16'h0FFF);

        // R6: rising stop input reloads
        repeat (320) @(negedge clk);
        stp_i = 1'b1;
        @(negedge clk); #1;
        read_at(8'h60, rd); check("R6 stop reload", rd, 16'h0FFF);
        stp_i = 1'b0;

        // R5: expiry at the 0x800 boundary
        reg_write(8'h60, 16'h0);
        wait_for_800(found);
        check("R5 reached 800", {15'b0, found}, 16'h0001);
        repeat (31) @(negedge clk);
        #1;
        check("R5 before expiry cnt", reg_rdata, 16'h0800);
        check("R5 before expiry irq", {15'b0, irq_o}, 16'h0000);
        @(negedge clk); #1;
        check("R5 expiry irq", {15'b0, irq_o}, 16'h0001);
        check("R5 expiry reload", reg_rdata, 16'h0FFF);

        // R10: request stays without acknowledge
        repeat (100) @(negedge clk);
        #1;
        check("R10 sticky", {15'b0, irq_o}, 16'h0001);

        // R10: expiry coincident with acknowledge keeps request
        wait_for_800(found);
        check("R10 reached 800", {15'b0, found}, 16'h0001);
        repeat (31) @(negedge clk);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        #1;
        check("R10 expiry beats ack", {15'b0, irq_o}, 16'h0001);
        check("R5 second reload", reg_rdata, 16'h0FFF);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        #1;
        check("R10 ack clears", {15'b0, irq_o}, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule